// File: doc/BRIEF.md
# AAL5 Super-Packet FIFO Accumulator

This block collects the payloads of consecutive reassembled AAL5 packets on a single connection into one receive buffer that behaves as a FIFO. Packets are written back to back, so many small packets form one large super packet that needs only one completion notification. Cells arrive one at a time as a full 48-byte payload with an end-of-packet flag. The block writes each cell into buffer memory as twelve 32-bit words, starting at the running byte offset inside the current buffer.

The super packet closes only at an AAL5 packet end, and only once the free space left in the buffer has dropped to a programmed largest-packet threshold. The buffer size limit comes from a 3-bit size code, clamped to the configured receive buffer size. A completion then reports the buffer base address, the total byte length and the number of AAL5 packets. It is issued either as a cut-through DMA descriptor request or as a super-packet event with code 0xE. A new buffer base address must be handed in before the next cell is taken. With the accumulator disabled, each AAL5 packet completes on its own.

Top module: `spf_accum`

## Requirements
- R1: After a synchronous reset, `conn_state` is 00 (down), `base_ready` is 1, `cell_ready` is 0, and `dma_req`, `evt_valid`, `ovf_pulse` and `mem_we` are 0.
- R2: A base address taken while `base_valid` and `base_ready` are both high moves `conn_state` to 01 (idle), drops `base_ready`, and allows `cell_ready` to be 1. `cell_ready` is 0 whenever `conn_state` is 00.
- R3: A cell that is accepted and fits in the buffer is written over the 12 cycles that follow the accepting edge. In the cycle k cycles after the first write (k = 0..11), `mem_we` is 1, `mem_addr` is base + offset + 4k, and `mem_wdata` is `cell_data[32k+31:32k]`. `cell_ready` is 0 throughout.
- R4: The byte offset grows by 48 for each written cell and is kept across packet ends that do not close the super packet. After such a packet end, `conn_state` is 10 (reassembling) and no completion is signalled.
- R5: With `cfg_fifo_en`=1, a packet end closes the super packet exactly when (size limit − offset after the last cell) ≤ `cfg_thresh`.
- R6: With `cfg_fifo_en`=0, every packet end closes the buffer. The result is a completion with a packet count of 1.
- R7: The size limit is min(1024 << `cfg_size_code`, BUF_BYTES) bytes.
- R8: A completion appears in the cycle after the last word is written. With `cfg_evt_mode`=0 it is a one-cycle `dma_req`. With `cfg_evt_mode`=1 it is a one-cycle `evt_valid` with `evt_code`=0xE. The two are never raised together. `done_addr` holds the base address, `done_len` the total bytes, and `done_npkt` the packet count.
- R9: After a completion, `conn_state` is 00 and the offset is 0. Cells are back-pressured until a new base address is taken, and the next super packet starts at offset 0 of the new base.
- R10: A cell that would push the offset past the size limit, and every later cell up to and including the next end-of-packet, is not written. Until that packet end, `conn_state` is 11 (error). The cycle after the end-of-packet cell is taken, `ovf_pulse` is 1, the offset returns to its value at the end of the last complete packet, and `conn_state` becomes 01 if that offset is 0, otherwise 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1: gather packets into a super packet; 0: complete each packet |
| cfg_evt_mode | input | 1 | Completion route: 0 DMA descriptor, 1 super-packet event |
| cfg_thresh | input | 13 | Largest expected packet in bytes (close threshold) |
| cfg_size_code | input | 3 | Buffer size code, limit 1024 << code bytes |
| base_valid | input | 1 | New buffer base address offered |
| base_ready | output | 1 | Block waits for a base address |
| base_addr | input | 32 | Byte address of the new buffer |
| cell_valid | input | 1 | Cell payload offered |
| cell_ready | output | 1 | Cell accepted when high together with cell_valid |
| cell_eop | input | 1 | Cell is the last one of an AAL5 packet |
| cell_data | input | 384 | 48-byte payload, byte i in bits 8i+7:8i |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 32 | Buffer write byte address |
| mem_wdata | output | 32 | Buffer write data |
| dma_req | output | 1 | One-cycle DMA descriptor request |
| evt_valid | output | 1 | One-cycle super-packet event |
| evt_code | output | 4 | Event code, 0xE with evt_valid |
| done_addr | output | 32 | Base address of the completed buffer |
| done_len | output | 16 | Byte length of the completed buffer |
| done_npkt | output | 12 | AAL5 packets in the completed buffer |
| ovf_pulse | output | 1 | One-cycle overflow report at the end of a dropped packet |
| conn_state | output | 2 | 00 down, 01 idle, 10 reassembling, 11 error |

## Verification
The assertions assume the four configuration inputs do not change while a super packet is open, and that BUF_BYTES is at most 65535. Under those conditions the offset can never exceed the size limit, and a completion always leaves the block down with a zero offset. The stimulus changes configuration only during reset or while the block waits for a new base address. It holds `cell_data` and `cell_eop` steady while `cell_valid` is high. Its random packets stay at or below the threshold, except in the directed overflow run, which breaks that limit on purpose to reach the error state.

// File: rtl/spf_pkg.sv
package spf_pkg;
    localparam int CELL_BYTES     = 48;
    localparam int DATA_W         = 32;
    localparam int WORD_BYTES     = DATA_W / 8;
    localparam int WORDS_PER_CELL = CELL_BYTES / WORD_BYTES;
    localparam int CELL_W         = CELL_BYTES * 8;
    localparam int ADDR_W         = 32;
    localparam int PTR_W          = 16;
    localparam int LEN_W          = PTR_W + 1;
    localparam int THR_W          = 13;
    localparam int NPKT_W         = 12;
    localparam logic [3:0] EVT_SUPER = 4'hE;

    typedef enum logic [1:0] {
        ST_DOWN  = 2'b00,
        ST_IDLE  = 2'b01,
        ST_REASM = 2'b10,
        ST_ERR   = 2'b11
    } conn_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PTR_W-1:0]  len;
        logic [NPKT_W-1:0] npkt;
    } done_t;

    // byte limit selected by a size code, clamped to the buffer size
    function automatic logic [LEN_W-1:0] cap_bytes(input logic [2:0] code,
                                                   input int unsigned lim);
        logic [17:0] raw;
        raw = 18'd1024 << code;
        if (raw > 18'(lim))
            return LEN_W'(lim);
        return raw[LEN_W-1:0];
    endfunction
endpackage

// File: rtl/spf_cell_writer.sv
module spf_cell_writer
    import spf_pkg::*;
#(
    parameter int WORDS = WORDS_PER_CELL,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORDS*DW-1:0] cell_in,
    input  logic [AW-1:0]       addr_in,
    output logic                busy,
    output logic                last,
    output logic                we,
    output logic [AW-1:0]       addr,
    output logic [DW-1:0]       wdata
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BW = DW / 8;

    logic                busy_q;
    logic [IW-1:0]       idx_q;
    logic [WORDS*DW-1:0] data_q;
    logic [AW-1:0]       addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            data_q <= cell_in;
            addr_q <= addr_in;
        end else if (busy_q) begin
            if (idx_q == IW'(WORDS - 1))
                busy_q <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    assign busy  = busy_q;
    assign last  = busy_q && (idx_q == IW'(WORDS - 1));
    assign we    = busy_q;
    assign addr  = addr_q + AW'(idx_q) * AW'(BW);
    assign wdata = data_q[int'(idx_q)*DW +: DW];

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q != IW'(WORDS - 1) && !start) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)); // R3
endmodule

// File: rtl/spf_ctl.sv
module spf_ctl
    import spf_pkg::*;
#(
    parameter int BUF_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fifo_en,
    input  logic              cfg_evt_mode,
    input  logic [THR_W-1:0]  cfg_thresh,
    input  logic [2:0]        cfg_size_code,
    input  logic              base_valid,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              base_ready,
    input  logic              acc,
    input  logic              acc_eop,
    input  logic              wr_last,
    output logic              can_take,
    output logic              wr_start,
    output logic [ADDR_W-1:0] wr_addr,
    output conn_st_e          state,
    output logic              dma_req,
    output logic              evt_valid,
    output logic [3:0]        evt_code,
    output done_t             done,
    output logic              ovf
);
    conn_st_e          st_q;
    logic [PTR_W-1:0]  ptr_q, pkt_start_q;
    logic [NPKT_W-1:0] npkt_q;
    logic [ADDR_W-1:0] base_q;
    logic              eop_q;

    logic [LEN_W-1:0]  cap, ptr_after, room;
    logic              over, close_now;

    assign cap       = cap_bytes(cfg_size_code, BUF_BYTES);
    assign ptr_after = {1'b0, ptr_q} + LEN_W'(CELL_BYTES);
    assign over      = ptr_after > cap;
    assign room      = cap - ptr_after;
    assign close_now = !cfg_fifo_en || (room <= LEN_W'(cfg_thresh));

    assign base_ready = (st_q == ST_DOWN);
    assign can_take   = (st_q != ST_DOWN);
    assign wr_start   = acc && (st_q != ST_ERR) && !over;
    assign wr_addr    = base_q + ADDR_W'(ptr_q);
    assign state      = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_DOWN;
            ptr_q       <= '0;
            pkt_start_q <= '0;
            npkt_q      <= '0;
            base_q      <= '0;
            eop_q       <= 1'b0;
            dma_req     <= 1'b0;
            evt_valid   <= 1'b0;
            evt_code    <= 4'h0;
            done        <= '0;
            ovf         <= 1'b0;
        end else begin
            dma_req   <= 1'b0;
            evt_valid <= 1'b0;
            evt_code  <= 4'h0;
            ovf       <= 1'b0;

            if (base_valid && base_ready) begin
                base_q <= base_addr;
                st_q   <= ST_IDLE;
            end

            if (wr_start) begin
                eop_q <= acc_eop;
                if (st_q == ST_IDLE)
                    st_q <= ST_REASM;
            end else if (acc) begin
                if (acc_eop) begin
                    ovf   <= 1'b1;
                    ptr_q <= pkt_start_q;
                    st_q  <= (pkt_start_q == '0) ? ST_IDLE : ST_REASM;
                end else begin
                    st_q <= ST_ERR;
                end
            end

            if (wr_last) begin
                if (eop_q && close_now) begin
                    done.addr   <= base_q;
                    done.len    <= ptr_after[PTR_W-1:0];
                    done.npkt   <= npkt_q + 1'b1;
                    dma_req     <= !cfg_evt_mode;
                    evt_valid   <= cfg_evt_mode;
                    evt_code    <= cfg_evt_mode ? EVT_SUPER : 4'h0;
                    ptr_q       <= '0;
                    pkt_start_q <= '0;
                    npkt_q      <= '0;
                    st_q        <= ST_DOWN;
                end else begin
                    ptr_q <= ptr_after[PTR_W-1:0];
                    if (eop_q) begin
                        pkt_start_q <= ptr_after[PTR_W-1:0];
                        npkt_q      <= npkt_q + 1'b1;
                    end
                end
            end
        end
    end

    AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
        !(dma_req && evt_valid)); // R8
    AST_EVT_CODE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code == EVT_SUPER)); // R8
    AST_PTR_IN_CAP: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ptr_q} <= cap)); // R10
    AST_DONE_TO_DOWN: assert property (@(posedge clk) disable iff (rst)
        (dma_req || evt_valid) |-> (st_q == ST_DOWN && ptr_q == '0)); // R9
    AST_BASE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (base_valid && base_ready) |=> (st_q == ST_IDLE)); // R2
endmodule

// File: rtl/spf_accum.sv
module spf_accum
    import spf_pkg::*;
#(
    parameter int BUF_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fifo_en,
    input  logic              cfg_evt_mode,
    input  logic [THR_W-1:0]  cfg_thresh,
    input  logic [2:0]        cfg_size_code,
    input  logic              base_valid,
    output logic              base_ready,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              cell_valid,
    output logic              cell_ready,
    input  logic              cell_eop,
    input  logic [CELL_W-1:0] cell_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dma_req,
    output logic              evt_valid,
    output logic [3:0]        evt_code,
    output logic [ADDR_W-1:0] done_addr,
    output logic [PTR_W-1:0]  done_len,
    output logic [NPKT_W-1:0] done_npkt,
    output logic              ovf_pulse,
    output logic [1:0]        conn_state
);
    logic              can_take, wr_busy, wr_last, wr_start, acc;
    logic [ADDR_W-1:0] wr_addr;
    conn_st_e          st;
    done_t             done;

    assign cell_ready = can_take && !wr_busy;
    assign acc        = cell_valid && cell_ready;
    assign conn_state = st;
    assign done_addr  = done.addr;
    assign done_len   = done.len;
    assign done_npkt  = done.npkt;

    spf_ctl #(.BUF_BYTES(BUF_BYTES)) u_ctl (
        .clk(clk), .rst(rst),
        .cfg_fifo_en(cfg_fifo_en), .cfg_evt_mode(cfg_evt_mode),
        .cfg_thresh(cfg_thresh), .cfg_size_code(cfg_size_code),
        .base_valid(base_valid), .base_addr(base_addr), .base_ready(base_ready),
        .acc(acc), .acc_eop(cell_eop), .wr_last(wr_last),
        .can_take(can_take), .wr_start(wr_start), .wr_addr(wr_addr),
        .state(st), .dma_req(dma_req), .evt_valid(evt_valid), .evt_code(evt_code),
        .done(done), .ovf(ovf_pulse)
    );

    spf_cell_writer #(.WORDS(WORDS_PER_CELL), .DW(DATA_W), .AW(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .start(wr_start),
        .cell_in(cell_data), .addr_in(wr_addr),
        .busy(wr_busy), .last(wr_last),
        .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
    );

    AST_NO_TAKE_WHILE_WRITING: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !cell_ready); // R3
    AST_DOWN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (conn_state == 2'b00) |-> !cell_ready); // R2
endmodule

// File: tb/sim_spf_accum.sv
`timescale 1ns/1ps
module sim_spf_accum;
    import spf_pkg::*;
    localparam int BUF_BYTES = 16384;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst, cfg_fifo_en, cfg_evt_mode;
    logic [12:0]       cfg_thresh;
    logic [2:0]        cfg_size_code;
    logic              base_valid, base_ready;
    logic [31:0]       base_addr;
    logic              cell_valid, cell_ready, cell_eop;
    logic [383:0]      cell_data;
    logic              mem_we, dma_req, evt_valid, ovf_pulse;
    logic [31:0]       mem_addr, mem_wdata, done_addr;
    logic [3:0]        evt_code;
    logic [15:0]       done_len;
    logic [11:0]       done_npkt;
    logic [1:0]        conn_state;

    spf_accum #(.BUF_BYTES(BUF_BYTES)) u0 (
        .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_evt_mode(cfg_evt_mode),
        .cfg_thresh(cfg_thresh), .cfg_size_code(cfg_size_code),
        .base_valid(base_valid), .base_ready(base_ready), .base_addr(base_addr),
        .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_eop(cell_eop),
        .cell_data(cell_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dma_req(dma_req), .evt_valid(evt_valid), .evt_code(evt_code),
        .done_addr(done_addr), .done_len(done_len), .done_npkt(done_npkt),
        .ovf_pulse(ovf_pulse), .conn_state(conn_state)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // reference model
    logic [31:0] m_base;
    int  m_ptr, m_pktstart, m_npkt;
    bit  m_err, m_down, rnd_mode, saw_done;
    int  last_len;

    function automatic int exp_cap(input int code);
        int r;
        r = 1024 << code;
        return (r > BUF_BYTES) ? BUF_BYTES : r;
    endfunction

    function automatic bit exp_close(input bit en, input int room, input int thr);
        return !en || (room <= thr);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                total++;
                summary();
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        cell_valid = 1'b0;
        base_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ptr = 0; m_pktstart = 0; m_npkt = 0;
        m_err = 1'b0; m_down = 1'b1;
        @(negedge clk);
    endtask

    task automatic give_base();
        m_base = $urandom & 32'hFFFF_FFFC;
        if (rnd_mode) cfg_evt_mode = 1'($urandom % 2);
        chk(base_ready == 1'b1, "R2", "base_ready before base", base_ready, 1);
        base_valid = 1'b1;
        base_addr = m_base;
        @(negedge clk);
        base_valid = 1'b0;
        chk(conn_state == 2'b01, "R2", "state after base", conn_state, 1);
        chk(base_ready == 1'b0 && cell_ready == 1'b1, "R2", "ready pair after base",
            {base_ready, cell_ready}, 2'b01);
        m_down = 1'b0;
    endtask

    task automatic send_cell(input bit eop);
        logic [383:0] cd;
        int cap, w;
        bit over, close;
        string rq;
        for (int k = 0; k < 12; k++) cd[32*k +: 32] = $urandom;
        if (m_down) give_base();
        cap = exp_cap(int'(cfg_size_code));
        over = (m_ptr + 48) > cap;
        w = 0;
        while (!cell_ready && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk(cell_ready == 1'b1, "R2", "cell_ready when open", cell_ready, 1);
        cell_valid = 1'b1;
        cell_data = cd;
        cell_eop = eop;
        @(negedge clk);
        cell_valid = 1'b0;
        if (m_err || over) begin
            chk(mem_we == 1'b0, "R10", "no write on dropped cell", mem_we, 0);
            if (eop) begin
                chk(ovf_pulse == 1'b1, "R10", "overflow pulse", ovf_pulse, 1);
                m_ptr = m_pktstart;
                m_err = 1'b0;
                chk(conn_state == ((m_ptr == 0) ? 2'b01 : 2'b10), "R10", "state after drop",
                    conn_state, (m_ptr == 0) ? 1 : 2);
            end else begin
                chk(ovf_pulse == 1'b0, "R10", "no pulse mid drop", ovf_pulse, 0);
                chk(conn_state == 2'b11, "R10", "error state", conn_state, 3);
                m_err = 1'b1;
            end
        end else begin
            for (int k = 0; k < 12; k++) begin
                chk(mem_we == 1'b1 && mem_addr == m_base + 32'(m_ptr) + 32'(4*k), "R3",
                    "write address", {31'b0, mem_we, mem_addr}, {32'd1, m_base + 32'(m_ptr) + 32'(4*k)});
                chk(mem_wdata == cd[32*k +: 32], "R3", "write data", mem_wdata, cd[32*k +: 32]);
                if (k == 0) chk(cell_ready == 1'b0, "R3", "busy backpressure", cell_ready, 0);
                @(negedge clk);
            end
            chk(mem_we == 1'b0, "R3", "write stops after 12", mem_we, 0);
            m_ptr += 48;
            if (eop) begin
                m_npkt++;
                close = exp_close(cfg_fifo_en, cap - m_ptr, int'(cfg_thresh));
                rq = cfg_fifo_en ? "R5" : "R6";
                if (close) begin
                    chk(dma_req == !cfg_evt_mode, rq, "dma_req on close", dma_req, !cfg_evt_mode);
                    chk(evt_valid == cfg_evt_mode, "R8", "evt_valid on close", evt_valid, cfg_evt_mode);
                    if (cfg_evt_mode) chk(evt_code == 4'hE, "R8", "event code", evt_code, 4'hE);
                    chk(done_addr == m_base, "R8", "done_addr", done_addr, m_base);
                    chk(done_len == 16'(m_ptr), "R8", "done_len", done_len, m_ptr);
                    chk(done_npkt == 12'(m_npkt), rq, "done_npkt", done_npkt, m_npkt);
                    chk(conn_state == 2'b00 && cell_ready == 1'b0, "R9", "down after close",
                        {conn_state, cell_ready}, 0);
                    saw_done = 1'b1;
                    last_len = m_ptr;
                    m_ptr = 0; m_pktstart = 0; m_npkt = 0; m_down = 1'b1;
                end else begin
                    chk(dma_req == 1'b0 && evt_valid == 1'b0, "R5", "no close yet",
                        {dma_req, evt_valid}, 0);
                    chk(conn_state == 2'b10, "R4", "reasm after packet end", conn_state, 2);
                    m_pktstart = m_ptr;
                end
            end else begin
                chk(dma_req == 1'b0 && evt_valid == 1'b0, "R4", "no completion mid packet",
                    {dma_req, evt_valid}, 0);
            end
        end
    endtask

    task automatic send_pkt(input int n);
        for (int i = 0; i < n; i++) send_cell(i == n - 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rnd_mode = 1'b0;
        saw_done = 1'b0;
        last_len = 0;
        cfg_fifo_en = 1'b1; cfg_evt_mode = 1'b0; cfg_thresh = 13'd240; cfg_size_code = 3'd0;
        base_addr = '0; cell_eop = 1'b0; cell_data = '0;
        do_reset();

        // R1: reset state
        chk(conn_state == 2'b00, "R1", "reset state", conn_state, 0);
        chk(base_ready == 1'b1 && cell_ready == 1'b0, "R1", "reset ready pair",
            {base_ready, cell_ready}, 2'b10);
        chk(!dma_req && !evt_valid && !ovf_pulse && !mem_we, "R1", "reset pulses",
            {dma_req, evt_valid, ovf_pulse, mem_we}, 0);

        // random packets, fifo mode, size 1024, threshold 240
        rnd_mode = 1'b1;
        for (int p = 0; p < 40; p++) send_pkt(1 + int'($urandom % 5));
        rnd_mode = 1'b0;

        // R6 per-packet completion and R9 back-pressure
        cfg_fifo_en = 1'b0; cfg_evt_mode = 1'b1;
        do_reset();
        send_pkt(2);
        chk(saw_done && last_len == 96, "R6", "single packet closes", last_len, 96);
        cell_valid = 1'b1; cell_eop = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(cell_ready == 1'b0 && mem_we == 1'b0, "R9", "held until new base",
                {cell_ready, mem_we}, 0);
        end
        cell_valid = 1'b0;
        send_pkt(1);
        chk(last_len == 48, "R9", "fresh buffer from offset 0", last_len, 48);

        // R7 clamp: code 7 limited to BUF_BYTES
        cfg_fifo_en = 1'b1; cfg_evt_mode = 1'b0; cfg_size_code = 3'd7; cfg_thresh = 13'd8191;
        do_reset();
        saw_done = 1'b0;
        for (int p = 0; p < 35; p++) send_pkt(5);
        chk(saw_done && last_len == 8400, "R7", "clamped limit closes", last_len, 8400);

        // R7 unclamped code 1 -> 2048
        cfg_size_code = 3'd1; cfg_thresh = 13'd1952;
        do_reset();
        saw_done = 1'b0;
        send_pkt(1);
        chk(saw_done == 1'b0, "R7", "no close at 2000 free", saw_done, 0);
        send_pkt(1);
        chk(saw_done && last_len == 96, "R7", "close at 1952 free", last_len, 96);

        // R10 overflow and rollback
        cfg_size_code = 3'd0; cfg_thresh = 13'd0;
        do_reset();
        for (int p = 0; p < 4; p++) send_pkt(5);
        send_pkt(3);
        chk(m_ptr == 960, "R10", "model rollback point", m_ptr, 960);
        send_pkt(1);
        send_pkt(1);
        send_pkt(2);

        summary();
    end
endmodule